// File: doc/BRIEF.md
# Sixteen-bit Compare and Capture Timer

This block is a general-purpose up-counter for a microcontroller-class subsystem. It counts pulses from one of two clock-enable inputs after a power-of-two divider. A single compare register is tested against the count on every divided tick. The relation used is selectable: equal, less than or greater than. When the relation holds, the block can record a match, request an interrupt, drive an output pin, and either clear the count or let it run on to full scale. A capture register takes a snapshot of the live count when a synchronized external input shows a selected edge. A wrap past full scale sets an overflow flag.

Software reaches the block through a small word-wide register port. The port has a control word, the compare value, the count (which can be loaded), the capture snapshot, and a status word whose bits are cleared by writing ones. The compare value can be rewritten while the counter runs, so that events can be spaced without resetting the count. The run control is a two-state machine. STOPPED goes to RUNNING when the run bit is seen set, and RUNNING goes back to STOPPED when it is seen clear. Ticks only pass in RUNNING, and the divider is held at zero in STOPPED.

Top module: `cc_timer`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is 0 and `pin_out` is 0.
- R2: Register map on `reg_addr`: 0 control, 1 compare, 2 count (a write loads the count and overrides any tick in that cycle), 3 capture (read-only), 4 status; other addresses read 0. Control bit 0 is run. Control bit 1 selects the enable source: 0 selects `tick_a`, 1 selects `tick_b`. The unselected enable has no effect. The count advances by one per divided tick, and only in RUNNING, which is entered on the clock edge after the run bit is written.
- R3: Control bits 4:2 give k, and the divider passes one tick for every 2^k selected enables. A value of 7 is treated as 6.
- R4: Control bits 6:5 select the relation of count to compare: 00 equal, 01 less than, 10 greater than, 11 equal. The relation is tested on the count held before each tick. A tick on which it holds is a match event and sets status bit 0.
- R5: When control bit 7 is set, a match event loads the count with 0 instead of incrementing it, so the period is compare+1 ticks in equal mode.
- R6: When control bit 9 is set, a match event changes `pin_out` as control bits 11:10 select: 00 keep, 01 set, 10 clear, 11 toggle. With bit 9 clear, `pin_out` is unchanged.
- R7: A tick at count 0xFFFF that is not a clearing match wraps the count to 0 and sets status bit 1.
- R8: `cap_in` passes through a two-flop synchronizer. Control bits 13:12 select the capture edge: 00 off, 01 rising, 10 falling, 11 both. On a selected edge, the count is copied to the capture register and status bit 2 is set. The copy lands on the second clock edge after the first edge that samples the new input level.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it. A flag set by hardware in the same cycle as its clear stays set.
- R10: `irq` is high when status bit 0 is set with control bit 8, status bit 1 with control bit 14, or status bit 2 with control bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_a | input | 1 | Count enable source 0 |
| tick_b | input | 1 | Count enable source 1 |
| cap_in | input | 1 | Asynchronous capture event input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on address |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Compare-driven output pin |

## Verification
A register write lands on the next rising edge. Because read data is combinational, the bench reads a register one cycle after the write. The count, status and pin change on the same edge as the divided tick that causes them, and `irq` follows status in that same cycle. The bench therefore stops the enables, waits one falling edge, and then reads. Entry into RUNNING takes one edge after the run bit is written, so enables are held low for two cycles after that write. The capture register is due on the third rising edge after `cap_in` changes, and the bench reads it after four. All samples are taken on falling edges, half a period away from the active edge.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int REG_W = 16;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CMP  = 3'd1;
    localparam logic [2:0] ADDR_CNT  = 3'd2;
    localparam logic [2:0] ADDR_CAP  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

    typedef enum logic [1:0] {
        REL_EQ  = 2'b00,
        REL_LT  = 2'b01,
        REL_GT  = 2'b10,
        REL_EQ2 = 2'b11
    } rel_e;

    typedef enum logic [1:0] {
        PIN_KEEP = 2'b00,
        PIN_SET  = 2'b01,
        PIN_CLR  = 2'b10,
        PIN_TGL  = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef struct packed {
        logic       cap_irq_en;
        logic       ovf_irq_en;
        logic [1:0] edge_sel;
        logic [1:0] pin_act;
        logic       pin_en;
        logic       match_irq_en;
        logic       clr_on_match;
        logic [1:0] rel;
        logic [2:0] psc;
        logic       src_sel;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int LOG_MAX = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       en_a,
    input  logic       en_b,
    input  logic       src_sel,
    input  logic [2:0] psc,
    output logic       tick
);
    localparam int DIV_W = (LOG_MAX > 0) ? LOG_MAX : 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [2:0]       log_eff;
    logic             en_sel;

    always_comb begin
        log_eff = (int'(psc) > LOG_MAX) ? 3'(LOG_MAX) : psc;
        mask    = DIV_W'((32'd1 << log_eff) - 32'd1);
        en_sel  = src_sel ? en_b : en_a;
        tick    = active && en_sel && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            div_q <= '0;
        end else if (en_sel) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/cct_compare.sv
module cct_compare
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   rel,
    output logic         match
);
    always_comb begin
        unique case (rel)
            REL_LT:  match = (cnt < cmp);
            REL_GT:  match = (cnt > cmp);
            default: match = (cnt == cmp);
        endcase
    end
endmodule

// File: rtl/cct_capture.sv
module cct_capture
    import cct_pkg::*;
#(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic [1:0]   edge_sel,
    input  logic [W-1:0] cnt,
    output logic         cap_evt,
    output logic [W-1:0] cap_val
);
    logic [STAGES:0] sh_q;
    logic            now_lvl, old_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], cap_in};
        end
    end

    always_comb begin
        now_lvl = sh_q[STAGES-1];
        old_lvl = sh_q[STAGES];
        unique case (edge_sel)
            EDGE_RISE: cap_evt = now_lvl && !old_lvl;
            EDGE_FALL: cap_evt = !now_lvl && old_lvl;
            EDGE_BOTH: cap_evt = now_lvl != old_lvl;
            default:   cap_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val <= '0;
        end else if (cap_evt) begin
            cap_val <= cnt;
        end
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cct_pkg::*;
#(
    parameter int PSC_LOG_MAX = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             cap_in,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             pin_out
);
    localparam int          NFLAG   = 3;
    localparam logic [REG_W-1:0] CNT_MAX = '1;

    ctrl_t            ctrl_q;
    logic [REG_W-1:0] cmp_q, cnt_q, cap_val;
    logic [NFLAG-1:0] stat_q, stat_clr, stat_set;
    logic             pin_q;
    run_state_e       state_q, state_d;
    logic             running, tick, match, match_evt, clr_now, ovf_evt, cap_evt;
    logic             wr_ctrl, wr_cmp, wr_cnt, wr_stat;

    assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    assign wr_cmp  = reg_we && (reg_addr == ADDR_CMP);
    assign wr_cnt  = reg_we && (reg_addr == ADDR_CNT);
    assign wr_stat = reg_we && (reg_addr == ADDR_STAT);

    // Run-control state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Next state and state outputs
    always_comb begin
        state_d = state_q;
        running = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                if (ctrl_q.run) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                running = 1'b1;
                if (!ctrl_q.run) state_d = ST_STOPPED;
            end
        endcase
    end

    cct_prescaler #(.LOG_MAX(PSC_LOG_MAX)) u_psc (
        .clk(clk), .rst_n(rst_n), .active(running),
        .en_a(tick_a), .en_b(tick_b), .src_sel(ctrl_q.src_sel),
        .psc(ctrl_q.psc), .tick(tick)
    );

    cct_compare #(.W(REG_W)) u_cmp (
        .cnt(cnt_q), .cmp(cmp_q), .rel(ctrl_q.rel), .match(match)
    );

    cct_capture #(.W(REG_W), .STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(ctrl_q.edge_sel),
        .cnt(cnt_q), .cap_evt(cap_evt), .cap_val(cap_val)
    );

    assign match_evt = tick && match;
    assign clr_now   = match && ctrl_q.clr_on_match;
    assign ovf_evt   = tick && !clr_now && (cnt_q == CNT_MAX);

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
            if (wr_cmp)  cmp_q  <= reg_wdata;
        end
    end

    // Counter: a software load wins over a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= reg_wdata;
        end else if (tick) begin
            cnt_q <= clr_now ? '0 : cnt_q + 1'b1;
        end
    end

    // Status flags: a hardware set beats a write-one clear
    always_comb begin
        stat_clr = wr_stat ? reg_wdata[NFLAG-1:0] : '0;
        stat_set = {cap_evt, ovf_evt, match_evt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    // Output pin action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (match_evt && ctrl_q.pin_en) begin
            unique case (ctrl_q.pin_act)
                PIN_SET:  pin_q <= 1'b1;
                PIN_CLR:  pin_q <= 1'b0;
                PIN_TGL:  pin_q <= !pin_q;
                default:  pin_q <= pin_q;
            endcase
        end
    end

    assign pin_out = pin_q;
    assign irq = (stat_q[0] && ctrl_q.match_irq_en)
              || (stat_q[1] && ctrl_q.ovf_irq_en)
              || (stat_q[2] && ctrl_q.cap_irq_en);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_CMP:  reg_rdata = cmp_q;
            ADDR_CNT:  reg_rdata = cnt_q;
            ADDR_CAP:  reg_rdata = cap_val;
            ADDR_STAT: reg_rdata = REG_W'(stat_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_chk.sv
module cct_chk
    import cct_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             tick,
    input logic             wr_cnt,
    input logic [REG_W-1:0] cnt,
    input logic             clr_now,
    input logic             match_evt,
    input logic             pin_en,
    input logic             pin_out,
    input logic             cap_evt,
    input logic [REG_W-1:0] cap_val,
    input logic [2:0]       stat
);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt)); // R2
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_now && !wr_cnt) |=> (cnt == '0)); // R5
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_evt && pin_en) |=> $stable(pin_out)); // R6
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_now && !wr_cnt && (cnt == '1)) |=> (stat[1] && cnt == '0)); // R7
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_val)); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> stat[0]); // R9
endmodule

bind cc_timer cct_chk u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .tick(tick), .wr_cnt(wr_cnt),
    .cnt(cnt_q), .clr_now(clr_now), .match_evt(match_evt), .pin_en(ctrl_q.pin_en),
    .pin_out(pin_out), .cap_evt(cap_evt), .cap_val(cap_val), .stat(stat_q)
);

// File: tb/cc_timer_test.sv
module cc_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b0, tick_b = 1'b0, cap_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = !clk;

    cc_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b), .cap_in(cap_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .pin_out(pin_out)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] cmp;
        logic [15:0] start;
        logic        use_b;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic [2:0]  exp_st;
        logic        exp_pin;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0E81, 16'd5,      16'd0,      1'b0, 8'd6,   16'd0,  3'd1, 1'b1}, // R5 R6 toggle
        '{16'h0001, 16'd5,      16'd0,      1'b0, 8'd6,   16'd6,  3'd1, 1'b0}, // R4 equal, no clear
        '{16'h0009, 16'd100,    16'd0,      1'b0, 8'd20,  16'd5,  3'd0, 1'b0}, // R3 divide 4
        '{16'h0001, 16'h1234,   16'hFFFE,   1'b0, 8'd3,   16'd1,  3'd2, 1'b0}, // R7 wrap
        '{16'h0621, 16'd3,      16'd10,     1'b0, 8'd4,   16'd14, 3'd0, 1'b0}, // R4 less-than miss
        '{16'h0641, 16'd3,      16'd10,     1'b0, 8'd1,   16'd11, 3'd1, 1'b1}, // R4 R6 greater, set
        '{16'h0AA1, 16'd3,      16'd0,      1'b0, 8'd3,   16'd0,  3'd1, 1'b0}, // R5 R6 clear action
        '{16'h0003, 16'd0,      16'd7,      1'b0, 8'd5,   16'd7,  3'd0, 1'b0}, // R2 unselected ignored
        '{16'h0003, 16'd0,      16'd7,      1'b1, 8'd5,   16'd12, 3'd0, 1'b0}, // R2 source b
        '{16'h001D, 16'h1000,   16'd0,      1'b0, 8'd128, 16'd2,  3'd0, 1'b0}, // R3 code 7 as 6
        '{16'h0005, 16'd1,      16'd0,      1'b0, 8'd5,   16'd2,  3'd1, 1'b0}  // R3 R4 divide 2
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_a = 1'b0; tick_b = 1'b0; cap_in = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic use_b, input int n);
        @(negedge clk);
        if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
        repeat (n) @(negedge clk);
        tick_a = 1'b0; tick_b = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        do_reset();

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 register reset", v, 16'h0000);
        end
        chk("R1 irq reset", {15'd0, irq}, 16'd0);
        chk("R1 pin reset", {15'd0, pin_out}, 16'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(3'd1, VECS[i].cmp);
            wr(3'd2, VECS[i].start);
            wr(3'd0, VECS[i].ctrl);
            repeat (2) @(negedge clk);
            pulse(VECS[i].use_b, int'(VECS[i].n));
            rd(3'd2, v);
            chk($sformatf("R2 vector %0d count", i), v, VECS[i].exp_cnt);
            rd(3'd4, v);
            chk($sformatf("R4 vector %0d status", i), v, {13'd0, VECS[i].exp_st});
            chk($sformatf("R6 vector %0d pin", i), {15'd0, pin_out}, {15'd0, VECS[i].exp_pin});
        end

        // R10 interrupt with R9 clear and set-wins
        do_reset();
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd5);
        wr(3'd0, 16'h0041);           // run, greater-than, irq off
        repeat (2) @(negedge clk);
        pulse(1'b0, 1);
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        wr(3'd0, 16'h0141);           // match irq enabled
        chk("R10 irq asserted", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h0001);
        rd(3'd4, v);
        chk("R9 write-one clear", v, 16'd0);
        chk("R10 irq follows clear", {15'd0, irq}, 16'd0);
        @(negedge clk);
        tick_a = 1'b1; reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0001;
        @(negedge clk);
        tick_a = 1'b0; reg_we = 1'b0;
        rd(3'd4, v);
        chk("R9 set beats clear", v, 16'd1);
        wr(3'd4, 16'h0000);
        rd(3'd4, v);
        chk("R9 write zero keeps", v, 16'd1);

        // R4 compare rewritten while running
        do_reset();
        wr(3'd1, 16'd3);
        wr(3'd0, 16'h0001);
        repeat (2) @(negedge clk);
        pulse(1'b0, 4);
        wr(3'd4, 16'h0007);
        wr(3'd1, 16'd6);
        pulse(1'b0, 2);
        rd(3'd4, v);
        chk("R4 new compare not yet hit", v, 16'd0);
        pulse(1'b0, 1);
        rd(3'd4, v);
        chk("R4 new compare hit", v, 16'd1);
        rd(3'd2, v);
        chk("R4 count kept running", v, 16'd7);

        // R8 capture edges, timer stopped
        do_reset();
        wr(3'd2, 16'h0042);
        wr(3'd0, 16'h9000);           // rising edge, capture irq on
        cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R8 rising capture", v, 16'h0042);
        rd(3'd4, v);
        chk("R8 capture flag", v, 16'd4);
        chk("R10 capture irq", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h0004);
        wr(3'd2, 16'h0055);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R8 falling ignored in rise mode", v, 16'h0042);
        rd(3'd4, v);
        chk("R8 no flag on ignored edge", v, 16'd0);
        wr(3'd0, 16'h2000);           // falling edge
        wr(3'd2, 16'h0077);
        cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R8 rising ignored in fall mode", v, 16'h0042);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R8 falling capture", v, 16'h0077);
        wr(3'd0, 16'h3000);           // both edges
        wr(3'd2, 16'h0099);
        cap_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R8 both-edge capture", v, 16'h0099);
        wr(3'd0, 16'h0000);           // capture off
        wr(3'd2, 16'h00AA);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd3, v);
        chk("R8 capture disabled", v, 16'h0099);

        // R2 count load wins over tick; unmapped read
        do_reset();
        wr(3'd0, 16'h0001);
        repeat (2) @(negedge clk);
        @(negedge clk);
        tick_a = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0300;
        @(negedge clk);
        tick_a = 1'b0; reg_we = 1'b0;
        rd(3'd2, v);
        chk("R2 load beats tick", v, 16'h0300);
        rd(3'd6, v);
        chk("R2 unmapped reads zero", v, 16'h0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule